// File: doc/BRIEF.md
# Multiplexed Device Bus Access Sequencer

This block runs read and write cycles on an external local bus where the address and data share one set of wires, qualified by an address latch enable strobe. It suits NOR flash, SRAM-like parts and FPGAs. A request port carries the address, up to four beats of write data, a burst length and a read/write flag. The block then drives chip select, output enable, write enable, the latch strobe, the shared bus and three low address bits.

Every timing interval is a cycle count taken from a configuration input. Read data is sampled at programmed points measured from the fall of the latch strobe. Write beats alternate a programmed enable-low phase and enable-high phase. After a read, a turn-off gap keeps the controller off the shared bus before the next access. A one-cycle done pulse returns the collected read data. The data path is 16 bits wide and also has an 8-bit mode. Only asynchronous devices on a single chip select are handled.

Top module: `devbus_seq`

## Requirements
- R1: A request is accepted only when `req_ready` is high, which is only while idle. The cycle after acceptance (cycle 0) is the latch cycle: `ale` is high for exactly that one cycle, `cs_n` goes low, `ad_oe` is high and `ad_out` carries the request address. Cycles are numbered from there, and cycle 1 is the first cycle after the strobe falls.
- R2: On a read, beat 0 is sampled from `ad_in` at the clock edge that ends cycle 1 + `cfg_acc_first`.
- R3: Each later read beat is sampled max(`cfg_acc_next`,1) cycles after the previous one. During a burst, `a_lo` advances to the next beat's address in the cycle after each sample.
- R4: `oe_n` goes low in cycle `cfg_rd_setup` and stays low through the last sample cycle L. A setup of 0 lowers it together with `cs_n` in cycle 0. The setting never moves any sample point.
- R5: `oe_n` is high in cycle L+1 whatever the hold setting. `done` pulses for one cycle in L+1, with beat j of the read data at `rd_data[16j+15:16j]`.
- R6: After a read, `cs_n` stays low through cycle L + `cfg_rd_hold`. A hold of 0 releases it in L+1.
- R7: After a read, `ad_oe` stays low and `req_ready` stays low until cycle L+1+max(`cfg_rd_hold`,`cfg_turn_off`). In that cycle `req_ready` rises.
- R8: On a write, `we_n` first falls in cycle 1 + `cfg_ale_wr`. Each beat holds it low for lo cycles and then high for hi cycles, where lo and hi are the programmed low and high counts with 0 raised to 1.
- R9: During a write, `ad_out` carries the data of the current beat from cycle 1 on. `ad_out` and `a_lo` change only at the start of a low phase, so they stay constant through each low phase and the high phase that follows it.
- R10: A write ends after the high phase of its last beat: with B beats, `cs_n` and `ad_oe` are low/high through cycle E = cfg_ale_wr + B(lo+hi). In E+1, `cs_n` rises, `done` pulses and `req_ready` is high, with no turn-off gap.
- R11: With `cfg_wide`=1, beats step `a_lo` by 2 and carry 16 bits. With `cfg_wide`=0, they step by 1: write data drives only bits 7:0 with bits 15:8 at zero, and sampled read bytes are zero-extended.
- R12: A `req_valid` raised while the block is busy has no effect: no further latch cycle occurs and the running access completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address of first beat |
| req_len | input | 2 | Beats minus one |
| req_wdata | input | 64 | Write data, beat j in bits 16j+15:16j |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 64 | Collected read beats, same packing as write data |
| cfg_rd_setup | input | 4 | Chip select to output enable delay, cycles |
| cfg_acc_first | input | 4 | Strobe fall to first sample, cycles |
| cfg_acc_next | input | 4 | Sample-to-sample spacing (0 acts as 1) |
| cfg_rd_hold | input | 4 | Last sample to chip select release |
| cfg_turn_off | input | 4 | Bus idle gap after a read |
| cfg_ale_wr | input | 4 | Strobe fall to first write enable |
| cfg_wr_low | input | 4 | Write enable low phase (0 acts as 1) |
| cfg_wr_high | input | 4 | Write enable high phase (0 acts as 1) |
| cfg_wide | input | 1 | 1 = 16-bit beats, 0 = 8-bit beats |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| ale | output | 1 | Address latch enable |
| a_lo | output | 3 | Low address bits of the current beat |
| ad_out | output | 16 | Shared bus drive value |
| ad_oe | output | 1 | Shared bus drive enable |
| ad_in | input | 16 | Shared bus receive value |

## Verification
Two events can land in the same cycle. The last read sample can coincide with the cycle in which `oe_n` would first fall when `cfg_rd_setup` is not below the sample point, and the chip select release can coincide with the output enable release when the hold count is 0. The bench sweeps every combination of setup, first delay, next delay, hold, turn-off and burst length over 0..2 (0..3 for length), so that both overlaps occur. In every cycle of every access it compares each strobe against windows computed arithmetically from the counts. A busy-time request pulse tests that the latch strobe never reappears mid-access.

// File: rtl/devbus_pkg.sv
package devbus_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LATCH = 3'd1,
    S_RWAIT = 3'd2,
    S_GAP   = 3'd3,
    S_WDLY  = 3'd4,
    S_WLO   = 3'd5,
    S_WHI   = 3'd6
  } bus_state_t;
endpackage

// File: rtl/devbus_req_reg.sv
module devbus_req_reg #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int LEN_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [AW-1:0]              addr_in,
  input  logic [(2**LEN_W)*DW-1:0]   wdata_in,
  output logic [AW-1:0]              addr_q,
  output logic [(2**LEN_W)*DW-1:0]   wdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end
endmodule

// File: rtl/devbus_rd_capture.sv
module devbus_rd_capture #(
  parameter int DW    = 16,
  parameter int LEN_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sample,
  input  logic [LEN_W-1:0]          beat,
  input  logic                      wide,
  input  logic [DW-1:0]             ad_in,
  output logic [(2**LEN_W)*DW-1:0]  rd_data
);
  localparam int NBEAT = 2**LEN_W;
  localparam int HALF  = DW/2;

  logic [DW-1:0] beat_val;
  always_comb begin
    beat_val = ad_in;
    if (!wide) beat_val[DW-1:HALF] = '0;
  end

  for (genvar b = 0; b < NBEAT; b++) begin : g_beat
    logic hit;
    assign hit = sample && (beat == LEN_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rd_data[b*DW +: DW] <= '0;
      else if (hit) rd_data[b*DW +: DW] <= beat_val;
    end
  end
endmodule

// File: rtl/devbus_fsm.sv
module devbus_fsm
  import devbus_pkg::*;
#(
  parameter int LEN_W = 2,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LEN_W-1:0] req_len,
  input  logic [CNT_W-1:0] cfg_rd_setup,
  input  logic [CNT_W-1:0] cfg_acc_first,
  input  logic [CNT_W-1:0] cfg_acc_next,
  input  logic [CNT_W-1:0] cfg_rd_hold,
  input  logic [CNT_W-1:0] cfg_turn_off,
  input  logic [CNT_W-1:0] cfg_ale_wr,
  input  logic [CNT_W-1:0] cfg_wr_low,
  input  logic [CNT_W-1:0] cfg_wr_high,
  output logic             accept,
  output logic             sample,
  output logic [LEN_W-1:0] beat,
  output logic             ready,
  output logic             done,
  output logic             cs_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             ale,
  output logic             ad_oe
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  bus_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, tcs_q, tcs_d;
  logic [LEN_W-1:0] beat_q, beat_d, len_q;
  logic             wr_q, done_q, done_d;

  logic [CNT_W-1:0] lo_n, hi_n, nx_n, gap_n, samp_tgt;
  logic             last;

  assign lo_n     = (cfg_wr_low   == '0) ? ONE : cfg_wr_low;
  assign hi_n     = (cfg_wr_high  == '0) ? ONE : cfg_wr_high;
  assign nx_n     = (cfg_acc_next == '0) ? ONE : cfg_acc_next;
  assign gap_n    = (cfg_rd_hold > cfg_turn_off) ? cfg_rd_hold : cfg_turn_off;
  assign samp_tgt = (beat_q == '0) ? cfg_acc_first : nx_n - ONE;
  assign last     = (beat_q == len_q);
  assign accept   = (st_q == S_IDLE) && req_valid;
  assign sample   = (st_q == S_RWAIT) && (cnt_q == samp_tgt);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q + ONE;
    tcs_d  = (&tcs_q) ? tcs_q : tcs_q + ONE;
    beat_d = beat_q;
    done_d = 1'b0;
    case (st_q)
      S_IDLE: begin
        cnt_d = '0;
        tcs_d = '0;
        if (accept) begin
          st_d   = S_LATCH;
          beat_d = '0;
        end
      end
      S_LATCH: begin
        cnt_d = '0;
        if (!wr_q)               st_d = S_RWAIT;
        else if (cfg_ale_wr == '0) st_d = S_WLO;
        else                     st_d = S_WDLY;
      end
      S_RWAIT: begin
        if (sample) begin
          cnt_d = '0;
          if (last) begin
            done_d = 1'b1;
            st_d   = (gap_n == '0) ? S_IDLE : S_GAP;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      S_GAP: begin
        if (cnt_q == gap_n - ONE) st_d = S_IDLE;
      end
      S_WDLY: begin
        if (cnt_q == cfg_ale_wr - ONE) begin
          cnt_d = '0;
          st_d  = S_WLO;
        end
      end
      S_WLO: begin
        if (cnt_q == lo_n - ONE) begin
          cnt_d = '0;
          st_d  = S_WHI;
        end
      end
      S_WHI: begin
        if (cnt_q == hi_n - ONE) begin
          cnt_d = '0;
          if (last) begin
            st_d   = S_IDLE;
            done_d = 1'b1;
          end else begin
            beat_d = beat_q + 1'b1;
            st_d   = S_WLO;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      tcs_q  <= '0;
      beat_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      tcs_q  <= tcs_d;
      beat_q <= beat_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      len_q <= '0;
    end else if (accept) begin
      wr_q  <= req_write;
      len_q <= req_len;
    end
  end

  logic in_wr, in_rd;
  assign in_wr = (st_q == S_WDLY) || (st_q == S_WLO) || (st_q == S_WHI);
  assign in_rd = ((st_q == S_LATCH) && !wr_q) || (st_q == S_RWAIT);

  assign beat  = beat_q;
  assign ready = (st_q == S_IDLE);
  assign done  = done_q;
  assign ale   = (st_q == S_LATCH);
  assign ad_oe = (st_q == S_LATCH) || in_wr;
  assign we_n  = (st_q != S_WLO);
  assign oe_n  = !(in_rd && (tcs_q >= cfg_rd_setup));
  assign cs_n  = !((st_q == S_LATCH) || (st_q == S_RWAIT) || in_wr ||
                   ((st_q == S_GAP) && (cnt_q < cfg_rd_hold)));

  // R1
  ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  // R12
  ale_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> $past(req_valid && ready));
  // R5
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && last) |=> (oe_n && done));
  // R7
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_GAP) |-> (!ad_oe && !ready && oe_n));
  // R8
  we_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cs_n && oe_n));
endmodule

// File: rtl/devbus_seq.sv
module devbus_seq #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int LEN_W = 2,
  parameter int CNT_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [AW-1:0]             req_addr,
  input  logic [LEN_W-1:0]          req_len,
  input  logic [(2**LEN_W)*DW-1:0]  req_wdata,
  output logic                      done,
  output logic [(2**LEN_W)*DW-1:0]  rd_data,
  input  logic [CNT_W-1:0]          cfg_rd_setup,
  input  logic [CNT_W-1:0]          cfg_acc_first,
  input  logic [CNT_W-1:0]          cfg_acc_next,
  input  logic [CNT_W-1:0]          cfg_rd_hold,
  input  logic [CNT_W-1:0]          cfg_turn_off,
  input  logic [CNT_W-1:0]          cfg_ale_wr,
  input  logic [CNT_W-1:0]          cfg_wr_low,
  input  logic [CNT_W-1:0]          cfg_wr_high,
  input  logic                      cfg_wide,
  output logic                      cs_n,
  output logic                      oe_n,
  output logic                      we_n,
  output logic                      ale,
  output logic [2:0]                a_lo,
  output logic [DW-1:0]             ad_out,
  output logic                      ad_oe,
  input  logic [DW-1:0]             ad_in
);
  localparam int HALF = DW/2;

  logic [1:0] rst_sync;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  logic                     accept, sample;
  logic [LEN_W-1:0]         beat;
  logic [AW-1:0]            addr_q;
  logic [(2**LEN_W)*DW-1:0] wdata_q;

  devbus_fsm #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_s), .req_valid(req_valid), .req_write(req_write),
    .req_len(req_len), .cfg_rd_setup(cfg_rd_setup), .cfg_acc_first(cfg_acc_first),
    .cfg_acc_next(cfg_acc_next), .cfg_rd_hold(cfg_rd_hold), .cfg_turn_off(cfg_turn_off),
    .cfg_ale_wr(cfg_ale_wr), .cfg_wr_low(cfg_wr_low), .cfg_wr_high(cfg_wr_high),
    .accept(accept), .sample(sample), .beat(beat), .ready(req_ready), .done(done),
    .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .ale(ale), .ad_oe(ad_oe)
  );

  devbus_req_reg #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_req (
    .clk(clk), .rst_n(rst_s), .load(accept), .addr_in(req_addr),
    .wdata_in(req_wdata), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  devbus_rd_capture #(.DW(DW), .LEN_W(LEN_W)) u_cap (
    .clk(clk), .rst_n(rst_s), .sample(sample), .beat(beat), .wide(cfg_wide),
    .ad_in(ad_in), .rd_data(rd_data)
  );

  logic [2:0]    beat_off;
  logic [DW-1:0] beat_data;
  assign beat_off = cfg_wide ? 3'({beat, 1'b0}) : 3'(beat);
  assign a_lo     = addr_q[2:0] + beat_off;

  always_comb begin
    beat_data = wdata_q[beat*DW +: DW];
    if (!cfg_wide) beat_data[DW-1:HALF] = '0;
  end
  assign ad_out = ale ? addr_q[DW-1:0] : beat_data;

  // R9
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(!we_n) && !we_n) |-> ($stable(ad_out) && $stable(a_lo)));
  // R10
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!we_n) |-> ad_oe);
endmodule

// File: tb/devbus_seq_bench.sv
`timescale 1ns/1ps
module devbus_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_len = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, done;
  logic [63:0] rd_data;
  logic [3:0]  c_rs = 0, c_af = 0, c_an = 0, c_hd = 0, c_to = 0, c_aw = 0, c_lo = 0, c_hi = 0;
  logic        c_wide = 1'b1;
  logic        cs_n, oe_n, we_n, ale, ad_oe;
  logic [2:0]  a_lo;
  logic [15:0] ad_out, ad_in;
  logic [7:0]  tag = 8'h00;

  int n_chk = 0, n_err = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign ad_in = {tag, 5'b0, a_lo};

  devbus_seq u_devbus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
    .cfg_rd_setup(c_rs), .cfg_acc_first(c_af), .cfg_acc_next(c_an),
    .cfg_rd_hold(c_hd), .cfg_turn_off(c_to), .cfg_ale_wr(c_aw),
    .cfg_wr_low(c_lo), .cfg_wr_high(c_hi), .cfg_wide(c_wide),
    .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .ale(ale), .a_lo(a_lo),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      if (n_err < 30) $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    finish_run();
  end

  function automatic logic [2:0] exp_alo(input logic [15:0] a, input int j, input bit w);
    return 3'(a[2:0] + (w ? 2*j : j));
  endfunction

  task automatic do_read(input int rs, af, an, hd, to, len, bit w, logic [15:0] addr);
    int n = (an == 0) ? 1 : an;
    int s0 = 1 + af;
    int l = s0 + len * n;
    int gap = (hd > to) ? hd : to;
    int kend = l + 1 + gap;
    c_rs = 4'(rs); c_af = 4'(af); c_an = 4'(an); c_hd = 4'(hd); c_to = 4'(to);
    c_wide = w; tag = tag + 8'h1d;
    req_write = 1'b0; req_addr = addr; req_len = 2'(len); req_valid = 1'b1;
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    @(posedge clk);
    for (int k = 0; k <= kend; k++) begin
      int j;
      @(negedge clk);
      req_valid = (k == 2 && kend > 3) ? 1'b1 : 1'b0;
      if (k == 2) req_addr = ~addr;
      j = (k <= s0) ? 0 : ((k - s0 + n - 1) / n);
      if (j > len) j = len;
      chk(ale == (k == 0), (k == 0) ? "R1" : "R12", ale, k == 0);
      chk(cs_n == !(k <= l + hd), "R6", cs_n, !(k <= l + hd));
      chk(oe_n == !(k >= rs && k <= l), (k == l + 1) ? "R5" : "R4", oe_n, !(k >= rs && k <= l));
      chk(ad_oe == (k == 0), "R7", ad_oe, k == 0);
      chk(done == (k == l + 1), "R5", done, k == l + 1);
      chk(req_ready == (k >= l + 1 + gap), "R7", req_ready, k >= l + 1 + gap);
      chk(we_n == 1'b1, "R8", we_n, 1);
      if (k == 0) chk(ad_out == addr, "R1", ad_out, addr);
      if (k <= l) chk(a_lo == exp_alo(addr, j, w), "R3", a_lo, exp_alo(addr, j, w));
      if (k == l + 1) begin
        for (int b = 0; b <= len; b++) begin
          logic [15:0] e;
          e = {(w ? tag : 8'h00), 5'b0, exp_alo(addr, b, w)};
          chk(rd_data[b*16 +: 16] == e, (b == 0) ? "R2" : (w ? "R3" : "R11"),
              rd_data[b*16 +: 16], e);
        end
      end
    end
    req_valid = 1'b0;
  endtask

  task automatic do_write(input int aw, wl, wh, len, bit w, logic [15:0] addr);
    int lo = (wl == 0) ? 1 : wl;
    int hi = (wh == 0) ? 1 : wh;
    int p = lo + hi;
    int w0 = 1 + aw;
    int e = w0 + (len + 1) * p - 1;
    logic [63:0] wd;
    c_aw = 4'(aw); c_lo = 4'(wl); c_hi = 4'(wh); c_wide = w;
    wd = {16'hd400 + 16'(len), 16'h9a33 ^ addr, 16'h5c21 + addr, 16'he7f0 ^ 16'(aw * 7 + wl)};
    req_write = 1'b1; req_addr = addr; req_len = 2'(len); req_wdata = wd; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R10", req_ready, 1);
    @(posedge clk);
    for (int k = 0; k <= e + 1; k++) begin
      int j;
      bit lowp;
      logic [15:0] ed;
      @(negedge clk);
      req_valid = (k == 2) ? 1'b1 : 1'b0;
      if (k == 2) req_addr = ~addr;
      j = (k < w0) ? 0 : (k - w0) / p;
      if (j > len) j = len;
      lowp = (k >= w0) && (k <= e) && (((k - w0) % p) < lo);
      ed = wd[j*16 +: 16];
      if (!w) ed[15:8] = 8'h00;
      chk(ale == (k == 0), (k == 0) ? "R1" : "R12", ale, k == 0);
      chk(we_n == !lowp, "R8", we_n, !lowp);
      chk(cs_n == !(k <= e), "R10", cs_n, !(k <= e));
      chk(ad_oe == (k <= e), "R10", ad_oe, k <= e);
      chk(oe_n == 1'b1, "R4", oe_n, 1);
      chk(done == (k == e + 1), "R10", done, k == e + 1);
      chk(req_ready == (k == e + 1), "R10", req_ready, k == e + 1);
      if (k == 0) chk(ad_out == addr, "R1", ad_out, addr);
      if (k >= 1 && k <= e) begin
        chk(ad_out == ed, w ? "R9" : "R11", ad_out, ed);
        chk(a_lo == exp_alo(addr, j, w), "R9", a_lo, exp_alo(addr, j, w));
      end
    end
    req_valid = 1'b0;
  endtask

  initial begin
    #12;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n && oe_n && we_n, "R1", {cs_n, oe_n, we_n}, 3'b111);
    chk(!ale && !ad_oe && !done, "R1", {ale, ad_oe, done}, 0);
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    for (int w = 1; w >= 0; w--)
      for (int len = 0; len < 4; len++)
        for (int af = 0; af < 3; af++)
          for (int an = 0; an < 3; an++)
            for (int rs = 0; rs < 3; rs++)
              for (int hd = 0; hd < 3; hd++)
                for (int to = 0; to < 3; to++)
                  do_read(rs, af, an, hd, to, len, w[0], 16'(16'h3a05 + len * 3 + af + rs * 5));
    for (int w = 1; w >= 0; w--)
      for (int len = 0; len < 4; len++)
        for (int aw = 0; aw < 3; aw++)
          for (int wl = 0; wl < 3; wl++)
            for (int wh = 0; wh < 3; wh++)
              do_write(aw, wl, wh, len, w[0], 16'(16'hb7c2 + len + aw * 3 + wh));
    finish_run();
  end
endmodule